// File: doc/BRIEF.md
# Reversible Cascade Truth-Table Checker

This block decides whether a programmed cascade of two-wire quantum gates realises a given reversible Boolean function. Software loads a target table of 2^N output patterns, one per input row, plus up to L stage descriptors and a stage count, through one indexed write port. A pulse on `start` launches a run. The checker first confirms that the target table is a permutation. It then feeds every basis-binary input row, in ascending order, through the cascade, one stage per clock. Each wire carries one of four symbolic values: 0, 1, Va (the square-root-of-NOT applied to 0) and Vb (applied to 1).

A row passes only when three things hold: no stage ever saw a non-binary or illegal control, every final wire is binary, and the final pattern equals the target row. The first failing row ends the run. At the end, `done` pulses and the verdict and the failing row are held. The gate cost, which is the number of two-wire stages in the programmed cascade, is always visible.

Top module: `rev_cascade_checker`

## Requirements
- R1: After reset `busy`, `done`, `pass` and `bad_target` are 0, the stage count is 0, the stages are all zero and the target table is the identity (row r maps to r). A run started from this state passes with cost 0.
- R2: Wire codes are 0=00, 1=01, Va=10, Vb=11. The bits of input row r feed the wires, bit q driving wire q. X maps 0↔1 and Va↔Vb. V maps 0→Va, 1→Vb, Va→1, Vb→0. Vd maps 0→Vb, 1→Va, Va→0, Vb→1. A stage word is {sel[2:0], ctrl, data}, where ctrl and data are 2-bit wire indices. Selectors: 0=X, 1=V, 2=Vd, 3=V after X, 4=Vd after X, 5=X after V, 6=X after Vd (each acts on the data wire when the control wire is 1), and 7=uncontrolled X on the data wire.
- R3: Each row keeps an error flag that starts at 0. The flag is set for the rest of the row by any controlled stage whose control wire is non-binary or equals its data wire, and by any stage whose wire index is N or more. Such a stage leaves the wires unchanged, and the row then fails even when its final outputs match.
- R4: A row passes only if its flag is 0 and every final wire is binary and equal to the corresponding target bit.
- R5: Rows are checked in ascending order and the run stops at the first failing row. That row's index appears on `fail_row`, and `pass` stays 0. When all rows pass, `pass`=1 and `fail_row`=0.
- R6: `gate_cost` equals the number of stages among the first count stages whose selector is not 7. A count write above L stores L.
- R7: Before any cascade evaluation, if a target output repeats an earlier row's output, the run ends with `bad_target`=1 and `pass`=0. `fail_row` then gives the first row whose output repeats.
- R8: Writes (kind 0 = target row at addr, 1 = stage at addr, 2 = stage count) are ignored while `busy` is 1.
- R9: `done` is high for exactly one cycle per run. `pass`, `bad_target` and `fail_row` are cleared by `start` and otherwise held after `done`.
- R10: A five-stage cascade realising the three-wire controlled-controlled-NOT passes with cost 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | 0 target row, 1 stage, 2 stage count |
| wr_addr | input | 3 | Row or stage index |
| wr_data | input | 7 | Target pattern, stage word or count |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | All rows matched |
| bad_target | output | 1 | Target table is not a permutation |
| fail_row | output | 3 | First failing or repeating row |
| gate_cost | output | 4 | Count of two-wire stages |

## Verification
A wrong wire value or a wrong stage function shows up as a wrong `pass` or a wrong `fail_row`. That happens at the `done` pulse of the first run whose row reaches the faulty case. Comparing the checker with an independent model over many generated cascades exposes such faults within one run. A flag that is not sticky or not cleared shows up as a wrong failing row. A corrupted target table during a run shows up only in the verdict of the next run, so that run is checked directly afterwards.

// File: rtl/rev_cascade_checker.sv
module rev_cascade_checker #(
  parameter int N = 3,
  parameter int L = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic wr_en,
  input  logic [1:0] wr_kind,
  input  logic [((N>$clog2(L))?N:$clog2(L))-1:0] wr_addr,
  input  logic [(((3+2*$clog2(N))>N)?(3+2*$clog2(N)):N)-1:0] wr_data,
  output logic busy,
  output logic done,
  output logic pass,
  output logic bad_target,
  output logic [N-1:0] fail_row,
  output logic [$clog2(L+1)-1:0] gate_cost
);
  localparam int ROWS = 1 << N;
  localparam int IW   = $clog2(N);
  localparam int SW   = 3 + 2*IW;
  localparam int CW   = $clog2(L+1);
  localparam int RW   = N;
  localparam int SAW  = $clog2(L);

  typedef logic [N-1:0][1:0] wv_t;
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_RUN} st_t;

  logic [ROWS-1:0][N-1:0] tgt;
  logic [L-1:0][SW-1:0]   stg;
  logic [CW-1:0]          nstg;

  st_t            st;
  logic [RW-1:0]  idx;
  logic [CW-1:0]  s;
  wv_t            wires, nxt;
  logic           flag;
  logic [ROWS-1:0] seen;

  assign busy = (st != S_IDLE);

  function automatic wv_t enc(input logic [RW-1:0] r);
    wv_t w;
    for (int q = 0; q < N; q++) w[q] = {1'b0, r[q]};
    return w;
  endfunction

  function automatic logic [1:0] fx(input logic [1:0] v);
    return {v[1], ~v[0]};
  endfunction
  function automatic logic [1:0] fv(input logic [1:0] v);
    return v[1] ? {1'b0, ~v[0]} : {1'b1, v[0]};
  endfunction
  function automatic logic [1:0] fvd(input logic [1:0] v);
    return v[1] ? {1'b0, v[0]} : {1'b1, ~v[0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) tgt[r] <= N'(r);
      stg  <= '0;
      nstg <= '0;
    end else if (wr_en && st == S_IDLE) begin
      case (wr_kind)
        2'd0: if (int'(wr_addr) < ROWS) tgt[wr_addr[RW-1:0]] <= wr_data[N-1:0];
        2'd1: if (int'(wr_addr) < L) stg[wr_addr[SAW-1:0]] <= wr_data[SW-1:0];
        2'd2: nstg <= (int'(wr_data[CW-1:0]) > L) ? CW'(L) : wr_data[CW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    gate_cost = '0;
    for (int i = 0; i < L; i++)
      if (i < int'(nstg) && stg[i][SW-1 -: 3] != 3'd7) gate_cost = gate_cost + CW'(1);
  end

  logic [SW-1:0] cur;
  logic [2:0]    sel;
  logic [IW-1:0] ci, di;
  logic [1:0]    cval, dval, newd;
  logic          cfound, dfound, ctrl_ok, act, bad_step, row_ok;

  assign cur = stg[s[SAW-1:0]];
  assign sel = cur[SW-1 -: 3];
  assign ci  = cur[2*IW-1:IW];
  assign di  = cur[IW-1:0];

  always_comb begin
    cval = 2'b00; dval = 2'b00; cfound = 1'b0; dfound = 1'b0;
    for (int q = 0; q < N; q++) begin
      if (ci == IW'(q)) begin cval = wires[q]; cfound = 1'b1; end
      if (di == IW'(q)) begin dval = wires[q]; dfound = 1'b1; end
    end
    ctrl_ok  = (sel == 3'd7) || (cfound && !cval[1] && ci != di);
    bad_step = !dfound || !ctrl_ok;
    act      = dfound && ((sel == 3'd7) || (ctrl_ok && cval[0]));
    case (sel)
      3'd0, 3'd7: newd = fx(dval);
      3'd1: newd = fv(dval);
      3'd2: newd = fvd(dval);
      3'd3: newd = fv(fx(dval));
      3'd4: newd = fvd(fx(dval));
      3'd5: newd = fx(fv(dval));
      default: newd = fx(fvd(dval));
    endcase
    nxt = wires;
    for (int q = 0; q < N; q++)
      if (act && di == IW'(q)) nxt[q] = newd;
  end

  always_comb begin
    row_ok = !flag;
    for (int q = 0; q < N; q++)
      if (wires[q][1] || wires[q][0] != tgt[idx][q]) row_ok = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; s <= '0; wires <= '0; flag <= 1'b0; seen <= '0;
      done <= 1'b0; pass <= 1'b0; bad_target <= 1'b0; fail_row <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_SCAN; idx <= '0; seen <= '0;
          pass <= 1'b0; bad_target <= 1'b0; fail_row <= '0;
        end
        S_SCAN: begin
          if (seen[tgt[idx]]) begin
            bad_target <= 1'b1; fail_row <= idx; done <= 1'b1; st <= S_IDLE;
          end else begin
            seen[tgt[idx]] <= 1'b1;
            if (idx == '1) begin
              st <= S_RUN; idx <= '0; wires <= enc('0); flag <= 1'b0; s <= '0;
            end else idx <= idx + 1'b1;
          end
        end
        S_RUN: begin
          if (s != nstg) begin
            wires <= nxt; flag <= flag | bad_step; s <= s + 1'b1;
          end else if (!row_ok) begin
            fail_row <= idx; done <= 1'b1; st <= S_IDLE;
          end else if (idx == '1) begin
            pass <= 1'b1; fail_row <= '0; done <= 1'b1; st <= S_IDLE;
          end else begin
            idx <= idx + 1'b1; wires <= enc(idx + 1'b1); flag <= 1'b0; s <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> ($stable(pass) && $stable(bad_target) && $stable(fail_row)));
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(tgt) && $stable(stg) && $stable(nstg)));
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && flag && s != nstg) |=> flag);
  a_r4_flag_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && s == nstg && flag) |=> (done && !pass));
  a_r7_bad_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
    bad_target |-> !pass);
  a_r5_pass_row0: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (fail_row == '0));
endmodule

// File: tb/sim_rev_cascade_checker.sv
module sim_rev_cascade_checker;
  logic clk = 0, rst_n = 0, start = 0, wr_en = 0;
  logic [1:0] wr_kind = 0;
  logic [2:0] wr_addr = 0;
  logic [6:0] wr_data = 0;
  logic busy, done, pass, bad_target;
  logic [2:0] fail_row;
  logic [3:0] gate_cost;
  int total = 0, bad = 0;
  int msel[8], mc[8], md[8], mtgt[8], mcnt;
  int unsigned seed = 32'h1234_5678;
  int tx[4] = '{1, 0, 3, 2};
  int tv[4] = '{2, 3, 1, 0};
  int tvd[4] = '{3, 2, 0, 1};

  rev_cascade_checker #(.N(3), .L(8)) u0 (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic wr(input int kind, input int addr, input int data);
    @(negedge clk); wr_en = 1; wr_kind = 2'(kind); wr_addr = 3'(addr); wr_data = 7'(data);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic put_stage(input int i, input int sl, input int c, input int d);
    msel[i] = sl; mc[i] = c; md[i] = d;
    wr(1, i, (sl << 4) | (c << 2) | d);
  endtask
  task automatic put_cnt(input int n); mcnt = n; wr(2, 0, n); endtask
  task automatic put_tgt(input int r, input int v); mtgt[r] = v; wr(0, r, v); endtask
  task automatic set_ident(); for (int r = 0; r < 8; r++) put_tgt(r, r); endtask

  task automatic model(output int ep, output int eb, output int er);
    int hit[8], w[3], flg;
    ep = 1; eb = 0; er = 0;
    for (int r = 0; r < 8; r++) hit[r] = 0;
    for (int r = 0; r < 8; r++) begin
      if (hit[mtgt[r]] != 0) begin ep = 0; eb = 1; er = r; return; end
      hit[mtgt[r]] = 1;
    end
    for (int r = 0; r < 8; r++) begin
      for (int q = 0; q < 3; q++) w[q] = (r >> q) & 1;
      flg = 0;
      for (int k = 0; k < mcnt; k++) begin
        if (md[k] > 2) flg = 1;
        else if (msel[k] == 7) w[md[k]] = tx[w[md[k]]];
        else if (mc[k] > 2 || mc[k] == md[k] || w[mc[k]] > 1) flg = 1;
        else if (w[mc[k]] == 1) begin
          case (msel[k])
            0: w[md[k]] = tx[w[md[k]]];
            1: w[md[k]] = tv[w[md[k]]];
            2: w[md[k]] = tvd[w[md[k]]];
            3: w[md[k]] = tv[tx[w[md[k]]]];
            4: w[md[k]] = tvd[tx[w[md[k]]]];
            5: w[md[k]] = tx[tv[w[md[k]]]];
            default: w[md[k]] = tx[tvd[w[md[k]]]];
          endcase
        end
      end
      for (int q = 0; q < 3; q++) if (w[q] != ((mtgt[r] >> q) & 1)) flg = 1;
      if (flg != 0) begin ep = 0; er = r; return; end
    end
  endtask

  task automatic do_run(output int p, output int b, output int fr);
    int n = 0;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done, "R9 done seen", done, 1);
    p = pass; b = bad_target; fr = fail_row;
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
  endtask

  task automatic expect_run(input string tag);
    int p, b, fr, ep, eb, er;
    model(ep, eb, er);
    do_run(p, b, fr);
    chk(p == ep, {tag, " pass"}, p, ep);
    chk(b == eb, {tag, " bad_target"}, b, eb);
    chk(fr == er, {tag, " fail_row"}, fr, er);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0, "R1 idle after reset", busy, 0);
    chk(pass == 0 && bad_target == 0, "R1 verdict after reset", pass, 0);
    chk(gate_cost == 0, "R1 cost after reset", gate_cost, 0);
    for (int r = 0; r < 8; r++) mtgt[r] = r;
    mcnt = 0;
    expect_run("R1 default run");
  endtask

  task automatic t_toffoli();
    set_ident();
    put_tgt(3, 7); put_tgt(7, 3);
    put_stage(0, 1, 1, 2); put_stage(1, 0, 0, 1); put_stage(2, 2, 1, 2);
    put_stage(3, 0, 0, 1); put_stage(4, 1, 0, 2); put_cnt(5);
    expect_run("R10 toffoli");
    chk(pass == 1, "R10 toffoli passes", pass, 1);
    chk(gate_cost == 5, "R6 toffoli cost", gate_cost, 5);
    put_stage(5, 7, 0, 1); put_stage(6, 7, 2, 1); put_cnt(7);
    chk(gate_cost == 5, "R6 inverters cost nothing", gate_cost, 5);
    expect_run("R2 toffoli plus inverter pair");
  endtask

  task automatic t_stage_funcs();
    set_ident();
    put_stage(0, 3, 0, 1); put_stage(1, 4, 0, 1); put_cnt(2);
    expect_run("R2 merged pair cancels");
    chk(pass == 1, "R2 merged pair identity", pass, 1);
    put_stage(0, 7, 1, 0); put_cnt(1);
    for (int r = 0; r < 8; r++) put_tgt(r, r ^ 1);
    expect_run("R2 inverter");
    chk(pass == 1, "R2 inverter passes", pass, 1);
  endtask

  task automatic t_flag();
    set_ident();
    put_stage(0, 1, 0, 1); put_stage(1, 0, 1, 2); put_stage(2, 2, 0, 1); put_cnt(3);
    expect_run("R3 nonbinary control");
    chk(fail_row == 1, "R3 nonbinary control row", fail_row, 1);
    put_stage(0, 0, 0, 0); put_cnt(1);
    expect_run("R3 ctrl equals data");
    chk(fail_row == 0, "R3 ctrl equals data row", fail_row, 0);
    put_stage(0, 0, 0, 3);
    expect_run("R3 index out of range");
  endtask

  task automatic t_final();
    set_ident();
    put_stage(0, 1, 0, 1); put_cnt(1);
    expect_run("R4 nonbinary output");
    chk(fail_row == 1 && pass == 0, "R4 nonbinary output fails", fail_row, 1);
    put_stage(0, 0, 0, 1);
    expect_run("R5 first mismatch");
    put_stage(0, 0, 2, 0);
    expect_run("R5 mismatch at row 4");
    chk(fail_row == 4, "R5 row 4", fail_row, 4);
  endtask

  task automatic t_bad_target();
    set_ident(); put_cnt(0);
    put_tgt(5, 2);
    expect_run("R7 duplicate");
    chk(bad_target == 1 && fail_row == 5, "R7 duplicate row", fail_row, 5);
    repeat (5) @(negedge clk);
    chk(bad_target == 1 && pass == 0, "R9 verdict held", bad_target, 1);
  endtask

  task automatic t_busy_write();
    int p, b, fr;
    set_ident(); put_cnt(0);
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    wr_en = 1; wr_kind = 0; wr_addr = 0; wr_data = 7'd1;
    @(negedge clk); wr_en = 1; wr_kind = 2; wr_data = 7'd3;
    @(negedge clk); wr_en = 0;
    while (!done) @(negedge clk);
    chk(pass == 1, "R8 run unaffected", pass, 1);
    do_run(p, b, fr);
    chk(p == 1 && b == 0, "R8 busy write ignored", p, 1);
    chk(gate_cost == 0, "R8 count write ignored", gate_cost, 0);
  endtask

  task automatic t_clamp();
    for (int i = 0; i < 8; i++) put_stage(i, 0, 1, 2);
    put_cnt(15); mcnt = 8;
    chk(gate_cost == 8, "R6 count clamped", gate_cost, 8);
    set_ident();
    expect_run("R6 clamped run");
  endtask

  task automatic t_random();
    int r;
    for (int it = 0; it < 40; it++) begin
      for (int i = 0; i < 8; i++) begin
        seed = seed * 1103515245 + 12345; r = int'(seed >> 16);
        if (it % 2 == 0) put_stage(i, r & 7, (r >> 3) % 3, (r >> 5) % 3);
        else put_stage(i, r & 7, (r >> 3) & 3, (r >> 5) & 3);
      end
      seed = seed * 1103515245 + 12345;
      put_cnt(int'((seed >> 16) % 9));
      expect_run("R2 random cascade");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_toffoli();
    t_stage_funcs();
    t_flag();
    t_final();
    t_bad_target();
    t_busy_write();
    t_clamp();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule